// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one block-transfer request into the stream of word addresses that a load-multiple or store-multiple operation needs. A request carries a base address, a 16-bit register list, an addressing-mode selector, a load/store flag and a writeback enable. It is captured on a start strobe. The sequencer then issues one beat for each set bit of the list. Each beat carries the register index and the 32-bit word address for that register, and it is offered on a valid/ready handshake so that a stalled memory port simply holds the current beat.

The selector either names one of the four direct addressing modes or names a stack type. A stack type is resolved to a direct mode in a different way for a store (push) than for a load (pop). In every mode the register with the lowest index lands at the lowest address. The decrement modes therefore first compute the bottom of the block and then walk upward. When the last beat is accepted, the block pulses done and, if writeback was requested, updates its base output to the written-back stack pointer.

Top module: `lsm_addr_seq`

## Requirements
- R1: With `mode_sel[2]`=0, `mode_sel[1:0]` selects a direct mode: 0 increment-after (first address = base), 1 increment-before (first = base+4), 2 decrement-after (first = base-4n+4), 3 decrement-before (first = base-4n), where n is the number of set bits in the list.
- R2: With `mode_sel[2]`=1, `mode_sel[1:0]` selects a stack type that is resolved by direction. 0 is full-descending: decrement-before for a store, increment-after for a load. 1 is full-ascending: increment-before for a store, decrement-after for a load. 2 is empty-descending: decrement-after for a store, increment-before for a load. 3 is empty-ascending: increment-after for a store, decrement-before for a load.
- R3: One beat is issued per set list bit, in ascending register index. Each accepted beat is followed by the next one at an address 4 higher, and exactly n beats are accepted before done.
- R4: The written-back value is base+4n for the increment modes and base-4n for the decrement modes. `base_out` takes it in the cycle done is high only if `wb_en` was set at start; otherwise `base_out` keeps its value.
- R5: An empty list gives no beat. done is high in the cycle after start is sampled, and the written-back value equals the base.
- R6: While `beat_valid` is high and `beat_ready` is low, the beat index and address stay unchanged.
- R7: A start strobe while a transfer is in progress is ignored and does not change the beats of the running transfer.
- R8: done is a single-cycle pulse in the cycle after the last beat is accepted, with `beat_valid` low. `beat_load` equals the load flag captured at start on every beat.
- R9: During and right after reset, `busy`, `beat_valid` and `done` are 0 and `base_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| base_addr | input | 32 | Base address of the request |
| reg_list | input | 16 | One bit per register to transfer |
| mode_sel | input | 3 | Bit 2 picks direct mode or stack type, bits 1:0 the code |
| is_load | input | 1 | 1 for load (pop), 0 for store (push) |
| wb_en | input | 1 | Write the final address back to `base_out` |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Memory side accepts the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_load | output | 1 | Direction of the beat |
| done | output | 1 | One-cycle end-of-transfer pulse |
| base_out | output | 32 | Last written-back base value |

## Verification
A bad pending-list state shows at the ports on the very next offered beat, as a repeated or skipped register index or a wrong beat count before done. A bad address register shows as a step other than 4 between accepted beats, and a bad start offset shows on the first beat. A wrong writeback value shows in the same cycle as done, on `base_out`. The sweep covers every selector code for both directions, lists from empty to full, and random ready stalls, so each of these faults appears within one transfer.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      AM_INC_AFTER  = 2'd0,
      AM_INC_BEFORE = 2'd1,
      AM_DEC_AFTER  = 2'd2,
      AM_DEC_BEFORE = 2'd3
   } am_e;

   typedef enum logic [1:0] {
      ST_FULL_DESC  = 2'd0,
      ST_FULL_ASC   = 2'd1,
      ST_EMPTY_DESC = 2'd2,
      ST_EMPTY_ASC  = 2'd3
   } stack_e;
endpackage

// File: rtl/lsm_mode_dec.sv
module lsm_mode_dec
   import lsm_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       is_load,
   output am_e        mode
);
   stack_e kind;
   assign kind = stack_e'(sel[1:0]);

   always_comb begin
      if (!sel[2]) begin
         mode = am_e'(sel[1:0]);
      end else begin
         unique case (kind)
            ST_FULL_DESC:  mode = is_load ? AM_INC_AFTER  : AM_DEC_BEFORE;
            ST_FULL_ASC:   mode = is_load ? AM_DEC_AFTER  : AM_INC_BEFORE;
            ST_EMPTY_DESC: mode = is_load ? AM_INC_BEFORE : AM_DEC_AFTER;
            default:       mode = is_load ? AM_DEC_BEFORE : AM_INC_AFTER;
         endcase
      end
   end
endmodule

// File: rtl/lsm_span_calc.sv
module lsm_span_calc
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [NREG-1:0]   list,
   input  am_e               mode,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] wb_addr
);
   localparam int CNT_W = $clog2(NREG + 1);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] bottom;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(list[i]);
   end

   assign span   = ADDR_W'(cnt) * STEP;
   assign bottom = base - span;

   always_comb begin
      unique case (mode)
         AM_INC_AFTER:  begin first_addr = base;          wb_addr = base + span; end
         AM_INC_BEFORE: begin first_addr = base + STEP;   wb_addr = base + span; end
         AM_DEC_AFTER:  begin first_addr = bottom + STEP; wb_addr = bottom;      end
         default:       begin first_addr = bottom;        wb_addr = bottom;      end
      endcase
   end
endmodule

// File: rtl/lsm_bit_pick.sv
module lsm_bit_pick #(
   parameter int NREG = 16
) (
   input  logic [NREG-1:0]         list,
   output logic [$clog2(NREG)-1:0] idx,
   output logic [NREG-1:0]         rest
);
   localparam int IDX_W = $clog2(NREG);

   logic [NREG:0]   below;
   logic [NREG-1:0] onehot;

   assign below[0] = 1'b0;
   for (genvar i = 0; i < NREG; i++) begin : g_scan
      assign onehot[i]  = list[i] & ~below[i];
      assign below[i+1] = below[i] | list[i];
   end

   assign rest = list & ~onehot;

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++)
         if (onehot[i]) idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       base_addr,
   input  logic [NREG-1:0]         reg_list,
   input  logic [2:0]              mode_sel,
   input  logic                    is_load,
   input  logic                    wb_en,
   output logic                    busy,
   output logic                    beat_valid,
   input  logic                    beat_ready,
   output logic [$clog2(NREG)-1:0] beat_reg,
   output logic [ADDR_W-1:0]       beat_addr,
   output logic                    beat_load,
   output logic                    done,
   output logic [ADDR_W-1:0]       base_out
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (NREG < 2) begin : g_bad_nreg
      $error("lsm_addr_seq: NREG must be at least 2");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("lsm_addr_seq: WORD_BYTES must be a power of two");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lsm_addr_seq: ADDR_W too small");
   end

   am_e               mode;
   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] wb_addr;
   logic [NREG-1:0]   rest;

   logic              busy_q;
   logic [NREG-1:0]   pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] wbv_q;
   logic              ld_q;
   logic              wben_q;
   logic              done_q;
   logic [ADDR_W-1:0] base_q;

   lsm_mode_dec u_dec (
      .sel     (mode_sel),
      .is_load (is_load),
      .mode    (mode)
   );

   lsm_span_calc #(
      .ADDR_W     (ADDR_W),
      .NREG       (NREG),
      .WORD_BYTES (WORD_BYTES)
   ) u_span (
      .base       (base_addr),
      .list       (reg_list),
      .mode       (mode),
      .first_addr (first_addr),
      .wb_addr    (wb_addr)
   );

   lsm_bit_pick #(
      .NREG (NREG)
   ) u_pick (
      .list (pend_q),
      .idx  (beat_reg),
      .rest (rest)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         addr_q <= '0;
         wbv_q  <= '0;
         ld_q   <= 1'b0;
         wben_q <= 1'b0;
         done_q <= 1'b0;
         base_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               ld_q   <= is_load;
               wben_q <= wb_en;
               wbv_q  <= wb_addr;
               addr_q <= first_addr;
               pend_q <= reg_list;
               if (reg_list == '0) begin
                  done_q <= 1'b1;
                  if (wb_en) base_q <= wb_addr;
               end else begin
                  busy_q <= 1'b1;
               end
            end
         end else if (beat_ready) begin
            pend_q <= rest;
            addr_q <= addr_q + STEP;
            if (rest == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               if (wben_q) base_q <= wbv_q;
            end
         end
      end
   end

   assign busy       = busy_q;
   assign beat_valid = busy_q;
   assign beat_addr  = addr_q;
   assign beat_load  = ld_q;
   assign done       = done_q;
   assign base_out   = base_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    busy,
   input logic                    beat_valid,
   input logic                    beat_ready,
   input logic [$clog2(NREG)-1:0] beat_reg,
   input logic [ADDR_W-1:0]       beat_addr,
   input logic                    done,
   input logic [ADDR_W-1:0]       base_out
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg))); // R6

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !beat_ready) |=> $stable(beat_addr)); // R7

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready) |=> (done || beat_addr == $past(beat_addr) + STEP)); // R3

   AST_INDEX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready) |=> (done || beat_reg > $past(beat_reg))); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !beat_valid); // R8

   AST_BASE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(base_out)); // R4
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(
   .ADDR_W     (ADDR_W),
   .NREG       (NREG),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .beat_valid (beat_valid),
   .beat_ready (beat_ready),
   .beat_reg   (beat_reg),
   .beat_addr  (beat_addr),
   .done       (done),
   .base_out   (base_out)
);

// File: tb/lsm_addr_seq_test.sv
`timescale 1ns/1ps
module lsm_addr_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] reg_list = '0;
   logic [2:0]  mode_sel = '0;
   logic        is_load = 1'b0;
   logic        wb_en = 1'b0;
   logic        busy, beat_valid, beat_load, done;
   logic        beat_ready = 1'b0;
   logic [3:0]  beat_reg;
   logic [31:0] beat_addr, base_out;

   int          checks = 0;
   int          failures = 0;
   int          cycles = 0;
   logic [15:0] lf = 16'hACE1;
   logic [31:0] exp_base = '0;

   always #4 clk = ~clk;

   lsm_addr_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .reg_list(reg_list), .mode_sel(mode_sel), .is_load(is_load), .wb_en(wb_en),
      .busy(busy), .beat_valid(beat_valid), .beat_ready(beat_ready),
      .beat_reg(beat_reg), .beat_addr(beat_addr), .beat_load(beat_load),
      .done(done), .base_out(base_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step_lf();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // Mode resolution per R1 and R2: 0 IA, 1 IB, 2 DA, 3 DB
   function automatic logic [1:0] exp_mode(input logic [2:0] sel, input logic ld);
      if (!sel[2]) return sel[1:0];
      case (sel[1:0])
         2'd0:    return ld ? 2'd0 : 2'd3;
         2'd1:    return ld ? 2'd2 : 2'd1;
         2'd2:    return ld ? 2'd1 : 2'd2;
         default: return ld ? 2'd3 : 2'd0;
      endcase
   endfunction

   task automatic run_xfer(input logic [2:0] sel, input logic ld, input logic wb,
                           input logic [15:0] list, input logic [31:0] base,
                           input bit stall, input bit poke);
      int n = 0;
      int k = 0;
      int guard = 0;
      int regs[16];
      logic [1:0]  m;
      logic [31:0] first, wbv;
      bit poked = 0;
      bit seen_done = 0;
      bit prev_stall = 0;
      for (int i = 0; i < 16; i++) if (list[i]) begin regs[n] = i; n++; end
      m = exp_mode(sel, ld);
      case (m)
         2'd0:    begin first = base;              wbv = base + 32'(4*n); end
         2'd1:    begin first = base + 4;          wbv = base + 32'(4*n); end
         2'd2:    begin first = base - 32'(4*n) + 4; wbv = base - 32'(4*n); end
         default: begin first = base - 32'(4*n);   wbv = base - 32'(4*n); end
      endcase
      if (wb) exp_base = wbv;
      start = 1'b1; base_addr = base; reg_list = list; mode_sel = sel;
      is_load = ld; wb_en = wb; beat_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      while (!seen_done && guard < 80) begin
         guard++;
         if (poked && start) start = 1'b0;
         if (done) begin
            seen_done = 1;
            chk(!beat_valid, "R8 no beat with done", {31'b0, beat_valid}, 0);
            chk(k == n, (n == 0) ? "R5 beat count" : "R3 beat count", k, n);
            chk(base_out == exp_base, (n == 0) ? "R5 wb base" : "R4 wb base", base_out, exp_base);
            beat_ready = 1'b0;
         end else if (beat_valid) begin
            if (k < n) begin
               chk(beat_reg == 4'(regs[k]), prev_stall ? "R6 reg held" : "R3 reg order",
                   {28'b0, beat_reg}, regs[k]);
               chk(beat_addr == first + 32'(4*k),
                   prev_stall ? "R6 addr held" : (k == 0 ? (sel[2] ? "R2 first addr" : "R1 first addr") : "R3 addr step"),
                   beat_addr, first + 32'(4*k));
               chk(beat_load == ld, "R8 beat_load", {31'b0, beat_load}, {31'b0, ld});
            end else begin
               chk(0, "R3 extra beat", k, n);
            end
            step_lf();
            beat_ready = !(stall && (lf[0] & lf[3]));
            if (poke && !poked) begin
               poked = 1;
               beat_ready = 1'b0;
               start = 1'b1; base_addr = ~base; reg_list = 16'hFFFF; mode_sel = 3'd3;
               is_load = ~ld;
            end
            prev_stall = !beat_ready;
            if (beat_ready) k++;
         end
         if (!seen_done) @(negedge clk);
      end
      start = 1'b0;
      chk(seen_done, poke ? "R7 done after ignored start" : "R8 done seen", {31'b0, seen_done}, 1);
      @(negedge clk);
      chk(!done, "R8 done single pulse", {31'b0, done}, 0);
   endtask

   initial begin
      logic [15:0] lists[7];
      lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000;
      lists[3] = 16'hFFFF; lists[4] = 16'h00A5; lists[5] = 16'h7E18;
      lists[6] = 16'h4202;
      repeat (3) @(negedge clk);
      chk(!busy && !beat_valid && !done, "R9 in reset", {29'b0, busy, beat_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !beat_valid && !done, "R9 after reset", {29'b0, busy, beat_valid, done}, 0);
      chk(base_out == 0, "R9 base_out", base_out, 0);

      for (int s = 0; s < 8; s++)
         for (int l = 0; l < 2; l++)
            for (int j = 0; j < 7; j++)
               run_xfer(3'(s), l[0], ((s + j) % 3) != 2, lists[j],
                        32'h0000_2000 + 32'(s * 256), (j % 2) == 1, 1'b0);

      // wrap-around near zero, writeback off keeps base
      run_xfer(3'd3, 1'b0, 1'b0, 16'hFFFF, 32'h0000_0010, 1'b1, 1'b0);
      run_xfer(3'd4, 1'b0, 1'b1, 16'hFFFF, 32'h0000_0010, 1'b0, 1'b0);
      // empty list, writeback on, must write base itself
      run_xfer(3'd6, 1'b1, 1'b1, 16'h0000, 32'h0000_5554, 1'b0, 1'b0);
      // start during busy is ignored
      run_xfer(3'd0, 1'b0, 1'b1, 16'h0003, 32'h0000_0100, 1'b0, 1'b1);
      run_xfer(3'd5, 1'b1, 1'b1, 16'h0C30, 32'h0000_0400, 1'b1, 1'b1);

      for (int r = 0; r < 40; r++) begin
         step_lf();
         run_xfer(3'(lf[2:0]), lf[5], lf[7], lf ^ 16'h5A3C, {16'h0001, lf[15:2], 2'b00}, 1'b1, 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule